// File: doc/BRIEF.md
# Topology-selectable parallel prefix adder

This block is an N-bit binary adder. It adds two operands and a carry-in and returns an N-bit sum and a carry-out. Every bit first forms a bitwise generate (A AND B) and a bitwise propagate (A XOR B). The carry-in is merged into bit 0, which is the same as treating it as a generate term at position −1. A valency-2 prefix network then combines the bits into group generate and propagate terms: G = G_hi | (P_hi & G_lo), P = P_hi & P_lo. The carry into bit i is the group generate over bits i−1 down to the carry-in. The sum is the propagate XOR that carry, and the carry-out is the group generate over the whole word.

The compile-time parameter `TOPO` sets the shape of the network:

| `TOPO` | Network | Rows of prefix cells |
|---|---|---|
| 0 | Kogge-Stone: every column combines with the column a power-of-two distance below it | log2 N |
| 1 | Brent-Kung: an up-sweep over the odd positions, then a down-sweep that fills the rest, with no more than one combine per column pair in a row | 2·log2 N − 1 |
| 2 | Sklansky: divide and conquer, where the fan-out of a row doubles from each row to the next | log2 N |
| 3 | Han-Carlson: a Kogge-Stone tree on the odd columns, with one row before it and one row after it | log2 N + 1 |

All four networks give bit-identical results. `N` must be a power of two and at least 4. A value of `N` or `TOPO` outside these ranges stops elaboration with an error. When `OUT_REG` is 1, the sum and carry-out pass through one register stage with an asynchronous active-low reset. When `OUT_REG` is 0, the adder is purely combinational.

The design has no state machine. Its only sequential element is the optional output register, which has two named conditions: RESET, where the outputs are held at zero, and RUN, where the outputs load every clock. The block moves from RESET to RUN when `rst_n` goes high, and from RUN back to RESET when `rst_n` goes low.

Top module: `pfx_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i`, computed at N+1 bits, for any operands.
- R2: The values 0 (Kogge-Stone), 1 (Brent-Kung), 2 (Sklansky) and 3 (Han-Carlson) of `TOPO` each produce results identical to R1.
- R3: With `OUT_REG`=1, a result appears on the outputs one rising clock edge after its operands are presented. With `OUT_REG`=0, the result follows the operands with no clock.
- R4: While `rst_n` is low, `sum_o` and `cout_o` read zero, whatever the inputs are, when `OUT_REG`=1.
- R5: When `a_i ^ b_i` is all ones (a full propagate chain), the carry-in travels the whole word. cin=1 gives sum 0 and carry-out 1. cin=0 gives sum all ones and carry-out 0.
- R6: When both operands are zero, sum bit 0 equals `cin_i`, all other sum bits are 0, and the carry-out is 0.
- R7: When both operands are all ones, the carry-out is 1, the upper N−1 sum bits are 1, and sum bit 0 equals `cin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | N | Sum |
| cout_o | output | 1 | Carry-out |

## Verification
With the register stage enabled, each result is due on the rising edge that follows the operands. The bench drives operands on a falling edge and samples one full period later, on the next falling edge, so the single register edge lies between driving and sampling. The combinational instance is sampled 1 ns after its operands change, with no clock edge in between. The reset checks keep non-zero operands applied through several edges and confirm the outputs stay at zero until the first edge after release.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int TOPO_KS = 0;
    localparam int TOPO_BK = 1;
    localparam int TOPO_SK = 2;
    localparam int TOPO_HC = 3;

    // number of rows of prefix cells for a topology at width 2**lg
    function automatic int row_count(input int topo, input int lg);
        case (topo)
            TOPO_KS: return lg;
            TOPO_BK: return 2 * lg - 1;
            TOPO_SK: return lg;
            TOPO_HC: return lg + 1;
            default: return 1;
        endcase
    endfunction

    // lower-side column that column i combines with in row s (1-based),
    // or -1 when the column only passes its value down
    function automatic int partner(input int topo, input int lg,
                                   input int s, input int i);
        int d;
        case (topo)
            TOPO_KS: begin
                d = 1 << (s - 1);
                return (i >= d) ? i - d : -1;
            end
            TOPO_SK: begin
                if (((i >> (s - 1)) & 1) == 1)
                    return ((i >> (s - 1)) << (s - 1)) - 1;
                return -1;
            end
            TOPO_BK: begin
                if (s <= lg) begin
                    d = 1 << s;
                    return (((i + 1) % d) == 0) ? i - d / 2 : -1;
                end
                d = 1 << (2 * lg - s);
                return ((((i + 1) % d) == d / 2) && (i >= d)) ? i - d / 2 : -1;
            end
            TOPO_HC: begin
                if (s == 1)
                    return ((i % 2) == 1) ? i - 1 : -1;
                if (s == lg + 1)
                    return (((i % 2) == 0) && (i >= 2)) ? i - 1 : -1;
                d = 1 << (s - 1);
                return (((i % 2) == 1) && (i >= d)) ? i - d : -1;
            end
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/pfx_bitpg.sv
module pfx_bitpg #(
    parameter int N = 64
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] g_o,      // bitwise generate, carry-in merged into bit 0
    output logic [N-1:0] p_grp_o,  // propagate entering the tree (bit 0 spans cin)
    output logic [N-1:0] p_bit_o   // raw bitwise propagate for the sum stage
);
    logic [N-1:0] gen_raw;

    always_comb begin
        gen_raw = a_i & b_i;
        p_bit_o = a_i ^ b_i;
        g_o     = {gen_raw[N-1:1], gen_raw[0] | (p_bit_o[0] & cin_i)};
        p_grp_o = {p_bit_o[N-1:1], 1'b0};
    end
endmodule

// File: rtl/pfx_cell.sv
module pfx_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_o,
    output logic p_o
);
    always_comb begin
        g_o = g_hi | (p_hi & g_lo);
        p_o = p_hi & p_lo;
    end
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
    parameter int N    = 64,
    parameter int TOPO = 0
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] grp_g_o
);
    localparam int LG   = $clog2(N);
    localparam int ROWS = pfx_pkg::row_count(TOPO, LG);

    logic g_st [ROWS+1][N];
    logic p_st [ROWS+1][N];

    if (N < 4 || (1 << LG) != N) begin : g_bad_width
        $error("pfx_tree: N must be a power of two of at least 4");
    end
    if (TOPO < 0 || TOPO > 3) begin : g_bad_topo
        $error("pfx_tree: unsupported TOPO value");
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        assign g_st[0][i] = g_i[i];
        assign p_st[0][i] = p_i[i];
    end

    for (genvar s = 1; s <= ROWS; s++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            localparam int J = pfx_pkg::partner(TOPO, LG, s, i);
            if (J >= 0) begin : g_comb
                pfx_cell u_cell (
                    .g_hi(g_st[s-1][i]),
                    .p_hi(p_st[s-1][i]),
                    .g_lo(g_st[s-1][J]),
                    .p_lo(p_st[s-1][J]),
                    .g_o (g_st[s][i]),
                    .p_o (p_st[s][i])
                );
            end else begin : g_pass
                assign g_st[s][i] = g_st[s-1][i];
                assign p_st[s][i] = p_st[s-1][i];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign grp_g_o[i] = g_st[ROWS][i];
    end
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
    parameter int N       = 64,
    parameter int TOPO    = pfx_pkg::TOPO_KS,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N-1:0] g_bit;
    logic [N-1:0] p_grp;
    logic [N-1:0] p_bit;
    logic [N-1:0] grp_g;
    logic [N-1:0] carry;
    logic [N-1:0] sum_c;
    logic         cout_c;

    pfx_bitpg #(.N(N)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .g_o    (g_bit),
        .p_grp_o(p_grp),
        .p_bit_o(p_bit)
    );

    pfx_tree #(.N(N), .TOPO(TOPO)) u_tree (
        .g_i    (g_bit),
        .p_i    (p_grp),
        .grp_g_o(grp_g)
    );

    always_comb begin
        carry  = {grp_g[N-2:0], cin_i};
        sum_c  = p_bit ^ carry;
        cout_c = grp_g[N-1];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                sum_o  <= sum_c;
                cout_o <= cout_c;
            end
        end
    end else begin : g_comb
        assign sum_o  = sum_c;
        assign cout_o = cout_c;
    end
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
    parameter int N       = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o
);
    logic [N:0] model;
    assign model = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

    if (OUT_REG) begin : g_seq
        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ({cout_o, sum_o} == $past(model)));
        assert_reset_R4: assert property (@(posedge clk)
            !rst_n |=> (sum_o == '0 && !cout_o));
        assert_prop_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((a_i ^ b_i) == '1) |=>
            ({cout_o, sum_o} == ($past(cin_i) ? {1'b1, {N{1'b0}}} : {1'b0, {N{1'b1}}})));
        assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (a_i == '0 && b_i == '0) |=>
            (!cout_o && sum_o == {{(N-1){1'b0}}, $past(cin_i)}));
        assert_all_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (a_i == '1 && b_i == '1) |=>
            (cout_o && sum_o == {{(N-1){1'b1}}, $past(cin_i)}));
    end else begin : g_cmb
        assert_sum_R1: assert property (@(posedge clk)
            ({cout_o, sum_o} == model));
        assert_prop_chain_R5: assert property (@(posedge clk)
            ((a_i ^ b_i) == '1) |->
            ({cout_o, sum_o} == (cin_i ? {1'b1, {N{1'b0}}} : {1'b0, {N{1'b1}}})));
        assert_zero_R6: assert property (@(posedge clk)
            (a_i == '0 && b_i == '0) |->
            (!cout_o && sum_o == {{(N-1){1'b0}}, cin_i}));
        assert_all_gen_R7: assert property (@(posedge clk)
            (a_i == '1 && b_i == '1) |->
            (cout_o && sum_o == {{(N-1){1'b1}}, cin_i}));
    end
endmodule

bind pfx_adder pfx_adder_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
);

// File: tb/sim_pfx_adder.sv
`timescale 1ns/1ps
module sim_pfx_adder;
    localparam int W  = 16;
    localparam int WC = 32;
    localparam int NV = 12;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W:0]   exp;
        int           req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{16'hFFFF, 16'h0001, 1'b0, 17'h1_0000, 1},
        '{16'h0000, 16'h0000, 1'b0, 17'h0_0000, 6},
        '{16'h0000, 16'h0000, 1'b1, 17'h0_0001, 6},
        '{16'hAAAA, 16'h5555, 1'b0, 17'h0_FFFF, 5},
        '{16'hAAAA, 16'h5555, 1'b1, 17'h1_0000, 5},
        '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF, 7},
        '{16'hFFFF, 16'hFFFF, 1'b0, 17'h1_FFFE, 7},
        '{16'h1234, 16'h4321, 1'b0, 17'h0_5555, 1},
        '{16'h8000, 16'h8000, 1'b0, 17'h1_0000, 1},
        '{16'h7FFF, 16'h0001, 1'b0, 17'h0_8000, 1},
        '{16'h00FF, 16'hFF01, 1'b0, 17'h1_0000, 1},
        '{16'hAAAA, 16'hAAAA, 1'b0, 17'h1_5554, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          cin = 1'b0;
    logic [W-1:0]  sum_t [4];
    logic          cout_t [4];
    logic [WC-1:0] ca = '0;
    logic [WC-1:0] cb = '0;
    logic          ccin = 1'b0;
    logic [WC-1:0] csum;
    logic          ccout;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    for (genvar t = 0; t < 4; t++) begin : g_topo
        pfx_adder #(.N(W), .TOPO(t), .OUT_REG(1'b1)) u0 (
            .clk   (clk),
            .rst_n (rst_n),
            .a_i   (a),
            .b_i   (b),
            .cin_i (cin),
            .sum_o (sum_t[t]),
            .cout_o(cout_t[t])
        );
    end

    pfx_adder #(.N(WC), .TOPO(3), .OUT_REG(1'b0)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (ca),
        .b_i   (cb),
        .cin_i (ccin),
        .sum_o (csum),
        .cout_o(ccout)
    );

    task automatic check(input string req, input int topo,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s topo=%0d actual=%h expected=%h", req, topo, act, exp);
        end
    endtask

    // drive on a falling edge, sample one period later (one register edge between)
    task automatic apply_and_check(input logic [W-1:0] va, input logic [W-1:0] vb,
                                   input logic vc, input logic [W:0] exp,
                                   input string req);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
        for (int t = 0; t < 4; t++)
            check(t == 0 ? req : "R2", t, {47'd0, cout_t[t], sum_t[t]}, {47'd0, exp});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R4: reset holds outputs at zero with non-zero operands applied
        a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
        repeat (3) @(negedge clk);
        for (int t = 0; t < 4; t++)
            check("R4", t, {47'd0, cout_t[t], sum_t[t]}, 64'd0);
        rst_n = 1'b1;
        #1;
        for (int t = 0; t < 4; t++)
            check("R4", t, {47'd0, cout_t[t], sum_t[t]}, 64'd0);

        // R3: output lags the operands by exactly one edge
        @(negedge clk);
        a = 16'h0003; b = 16'h0004; cin = 1'b0;
        @(posedge clk);
        #1;
        check("R3", 0, {47'd0, cout_t[0], sum_t[0]}, 64'h7);
        a = 16'h0010; b = 16'h0001;
        #2;
        check("R3", 0, {47'd0, cout_t[0], sum_t[0]}, 64'h7);
        @(posedge clk);
        #1;
        check("R3", 0, {47'd0, cout_t[0], sum_t[0]}, 64'h11);

        // table of vectors, R1 on Kogge-Stone, R2 on the others
        for (int k = 0; k < NV; k++)
            apply_and_check(TBL[k].a, TBL[k].b, TBL[k].cin, TBL[k].exp,
                            $sformatf("R%0d", TBL[k].req));

        // random vectors against the bench's own sum, R1 and R2
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic         rc;
            ra = W'($urandom);
            rb = W'($urandom);
            rc = 1'($urandom);
            apply_and_check(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc}, "R1");
        end

        // R3 combinational variant, sampled 1 ns after the operands change
        for (int k = 0; k < 40; k++) begin
            logic [WC:0] e;
            ca = (k == 0) ? '1 : WC'($urandom);
            cb = (k == 0) ? 32'd1 : (k == 1) ? ~ca : WC'($urandom);
            ccin = (k == 1) ? 1'b1 : 1'($urandom);
            e = {1'b0, ca} + {1'b0, cb} + {{WC{1'b0}}, ccin};
            #1;
            check("R3", 3, {31'd0, ccout, csum}, {31'd0, e});
            #3;
        end

        // R4: reset asserted again mid-run clears the outputs
        @(negedge clk);
        a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
        rst_n = 1'b0;
        #1;
        for (int t = 0; t < 4; t++)
            check("R4", t, {47'd0, cout_t[t], sum_t[t]}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 4; t++)
            check("R7", t, {47'd0, cout_t[t], sum_t[t]}, 64'h1_FFFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule